// File: doc/BRIEF.md
# Loop Counter and Compare-Branch Unit

This block sits beside a small processor's sequencer. It keeps an iteration counter for software loops and decides whether a conditional branch is taken. The instruction decoder hands it already-decoded command strobes together with three operands. The first is the contents of the fixed comparison register (register 31). The second is the contents of a register chosen by the instruction, called A. The third is the alternate address carried by the instruction. The program counter, the memory and the arithmetic unit live elsewhere. The sequencer only consumes the taken pulse and the target address that this unit produces.

A one-bit mode selects the left-hand operand of every comparison. In compare mode the operand is register 31. In count mode it is the unit's own loop counter, so a loop can branch on its iteration count directly. All comparisons treat both operands as unsigned. Every output is registered. A branch decision appears on the clock edge that follows the cycle in which the compare command was presented.

Top module: `loopBranchUnit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves the counter at 0, the unit in compare mode, `jumpTaken` at 0 and `jumpTarget` at 0.
- R2: With `clrCnt` high at an edge, `loopCount` is 0 after that edge.
- R3: With `incCnt` high and `clrCnt` low at an edge, `loopCount` grows by one and wraps from 255 to 0. With both low, it keeps its value.
- R4: When `clrCnt` and `incCnt` are both high at the same edge, the clear wins and `loopCount` becomes 0.
- R5: Each edge with `flipMode` high swaps compare mode and count mode. A compare presented in that same cycle still uses the mode in force before the swap.
- R6: `cmpOp` = 2'b01 (greater) takes the branch when the selected operand is greater than `regA`, compared unsigned.
- R7: `cmpOp` = 2'b10 (less) takes the branch when the selected operand is less than `regA`, compared unsigned.
- R8: `cmpOp` = 2'b11 (equal) takes the branch when the selected operand equals `regA`.
- R9: The selected operand is `regTop` in compare mode and `loopCount` in count mode. In count mode it is the counter value before any clear or increment applied at the same edge.
- R10: After an edge where the condition holds, `jumpTaken` is 1 for exactly that one cycle and `jumpTarget` equals the `altAddr` presented with the command. At every other time, including after `cmpOp` = 2'b00 (no compare), both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clrCnt | input | 1 | Clear loop counter command |
| incCnt | input | 1 | Increment loop counter command |
| flipMode | input | 1 | Swap compare/count mode command |
| cmpOp | input | 2 | Compare command: 00 none, 01 greater, 10 less, 11 equal |
| regTop | input | DATA_W | Contents of register 31 |
| regA | input | DATA_W | Contents of the selected register A |
| altAddr | input | ADDR_W | Alternate address carried by the instruction |
| loopCount | output | DATA_W | Current loop counter value |
| jumpTaken | output | 1 | One-cycle branch-taken pulse |
| jumpTarget | output | ADDR_W | Branch target while taken, else 0 |

## Verification
The bench targets the unsigned boundary with 0x80 against 0x7F. A signed comparator would invert that decision. It also drives the counter across the 255-to-0 wrap, which a wider or saturating counter would get wrong. It raises clear and increment together to catch a design that lets the increment win. It issues a compare in the same cycle as a mode swap or an increment, which exposes a unit that reads the post-update mode or counter. Finally it checks that the taken pulse drops after one cycle and that the target returns to zero. A design that held its outputs would leave a stale branch visible to the sequencer.

// File: rtl/loopBranchPkg.sv
package loopBranchPkg;

  typedef enum logic [1:0] {
    CMP_NONE = 2'b00,
    CMP_GT   = 2'b01,
    CMP_LT   = 2'b10,
    CMP_EQ   = 2'b11
  } cmpOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   clear;
    logic   step;
    logic   cmpEn;
    cmpOp_e op;
    logic   useCount;
  } lbStrobe_t;

endpackage

// File: rtl/lbCompare.sv
module lbCompare
  import loopBranchPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  input  cmpOp_e            op,
  output logic              hit
);

  logic isGreater;
  logic isLess;
  logic isEqual;

  // unsigned relations
  assign isGreater = lhs > rhs;
  assign isLess    = lhs < rhs;
  assign isEqual   = lhs == rhs;

  always_comb begin
    unique case (op)
      CMP_GT:  hit = isGreater;
      CMP_LT:  hit = isLess;
      CMP_EQ:  hit = isEqual;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/lbControl.sv
module lbControl
  import loopBranchPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clrCnt,
  input  logic       incCnt,
  input  logic       flipMode,
  input  logic [1:0] cmpOp,
  output lbStrobe_t  strobe
);

  logic   countMode;
  cmpOp_e opDec;

  assign opDec = cmpOp_e'(cmpOp);

  always_ff @(posedge clk) begin
    if (rst) begin
      countMode <= 1'b0;
    end else if (flipMode) begin
      countMode <= ~countMode;
    end
  end

  always_comb begin
    strobe.clear    = clrCnt;
    strobe.step     = incCnt & ~clrCnt;
    strobe.cmpEn    = (opDec != CMP_NONE);
    strobe.op       = opDec;
    strobe.useCount = countMode;   // mode before this cycle's flip
  end

endmodule

// File: rtl/lbDatapath.sv
module lbDatapath
  import loopBranchPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  lbStrobe_t         strobe,
  input  logic [DATA_W-1:0] regTop,
  input  logic [DATA_W-1:0] regA,
  input  logic [ADDR_W-1:0] altAddr,
  output logic [DATA_W-1:0] loopCount,
  output logic              jumpTaken,
  output logic [ADDR_W-1:0] jumpTarget
);

  localparam logic [DATA_W-1:0] CNT_ONE  = DATA_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_NIL = '0;

  logic [DATA_W-1:0] lhsSel;
  logic              condHit;
  logic              takeNow;

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      loopCount <= '0;
    end else if (strobe.step) begin
      loopCount <= loopCount + CNT_ONE;
    end
  end

  assign lhsSel = strobe.useCount ? loopCount : regTop;

  lbCompare #(.DATA_W(DATA_W)) cmpUnit (
    .lhs (lhsSel),
    .rhs (regA),
    .op  (strobe.op),
    .hit (condHit)
  );

  assign takeNow = strobe.cmpEn & condHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      jumpTaken  <= 1'b0;
      jumpTarget <= ADDR_NIL;
    end else begin
      jumpTaken  <= takeNow;
      jumpTarget <= takeNow ? altAddr : ADDR_NIL;
    end
  end

endmodule

// File: rtl/loopBranchUnit.sv
module loopBranchUnit
  import loopBranchPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clrCnt,
  input  logic              incCnt,
  input  logic              flipMode,
  input  logic [1:0]        cmpOp,
  input  logic [DATA_W-1:0] regTop,
  input  logic [DATA_W-1:0] regA,
  input  logic [ADDR_W-1:0] altAddr,
  output logic [DATA_W-1:0] loopCount,
  output logic              jumpTaken,
  output logic [ADDR_W-1:0] jumpTarget
);

  lbStrobe_t strobe;

  lbControl ctrl (
    .clk      (clk),
    .rst      (rst),
    .clrCnt   (clrCnt),
    .incCnt   (incCnt),
    .flipMode (flipMode),
    .cmpOp    (cmpOp),
    .strobe   (strobe)
  );

  lbDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dpath (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .regTop     (regTop),
    .regA       (regA),
    .altAddr    (altAddr),
    .loopCount  (loopCount),
    .jumpTaken  (jumpTaken),
    .jumpTarget (jumpTarget)
  );

endmodule

// File: rtl/loopBranchChecker.sv
module loopBranchChecker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              clrCnt,
  input logic              incCnt,
  input logic [1:0]        cmpOp,
  input logic [DATA_W-1:0] regTop,
  input logic [DATA_W-1:0] regA,
  input logic [ADDR_W-1:0] altAddr,
  input logic [DATA_W-1:0] loopCount,
  input logic              jumpTaken,
  input logic [ADDR_W-1:0] jumpTarget
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (loopCount == '0 && !jumpTaken && jumpTarget == '0)); // R1

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clrCnt |=> loopCount == '0); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (incCnt && !clrCnt) |=> loopCount == $past(loopCount) + 1'b1); // R3

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!incCnt && !clrCnt) |=> $stable(loopCount)); // R3

  AST_EQ_BOTH_SOURCES: assert property (@(posedge clk) disable iff (rst)
    (cmpOp == 2'b11 && regA == regTop && regA == loopCount) |=> jumpTaken); // R8

  AST_IDLE_NO_JUMP: assert property (@(posedge clk) disable iff (rst)
    (cmpOp == 2'b00) |=> !jumpTaken); // R10

  AST_TARGET_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !jumpTaken |-> jumpTarget == '0); // R10

  AST_TARGET_COPY: assert property (@(posedge clk) disable iff (rst)
    (cmpOp != 2'b00) |=> (!jumpTaken || jumpTarget == $past(altAddr))); // R10

endmodule

bind loopBranchUnit loopBranchChecker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk (
  .clk        (clk),
  .rst        (rst),
  .clrCnt     (clrCnt),
  .incCnt     (incCnt),
  .cmpOp      (cmpOp),
  .regTop     (regTop),
  .regA       (regA),
  .altAddr    (altAddr),
  .loopCount  (loopCount),
  .jumpTaken  (jumpTaken),
  .jumpTarget (jumpTarget)
);

// File: tb/loopBranchUnit_test.sv
module loopBranchUnit_test;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              clrCnt = 1'b0;
  logic              incCnt = 1'b0;
  logic              flipMode = 1'b0;
  logic [1:0]        cmpOp = 2'b00;
  logic [DATA_W-1:0] regTop = '0;
  logic [DATA_W-1:0] regA = '0;
  logic [ADDR_W-1:0] altAddr = '0;
  logic [DATA_W-1:0] loopCount;
  logic              jumpTaken;
  logic [ADDR_W-1:0] jumpTarget;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loopBranchUnit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // present one command for one edge, then return to idle
  task automatic issue(input logic c, input logic i, input logic f, input logic [1:0] op,
                       input int top, input int a, input int addr);
    @(negedge clk);
    clrCnt = c; incCnt = i; flipMode = f; cmpOp = op;
    regTop = DATA_W'(top); regA = DATA_W'(a); altAddr = ADDR_W'(addr);
    @(posedge clk); #1;
    clrCnt = 0; incCnt = 0; flipMode = 0; cmpOp = 2'b00;
  endtask

  task automatic idle();
    issue(0, 0, 0, 2'b00, 0, 0, 0);
  endtask

  task automatic expectJump(input string req, input logic taken, input int addr);
    check(req, int'(jumpTaken), int'(taken));
    check(req, int'(jumpTarget), taken ? addr : 0);
  endtask

  task automatic setCount(input int n);
    issue(1, 0, 0, 2'b00, 0, 0, 0);
    for (int k = 0; k < n; k++) issue(0, 1, 0, 2'b00, 0, 0, 0);
  endtask

  task automatic testReset();
    @(negedge clk); rst = 1;
    @(posedge clk); #1; rst = 0;
    check("R1 count", int'(loopCount), 0);
    expectJump("R1 outputs", 0, 0);
    issue(0, 0, 0, 2'b11, 9, 9, 33);   // equal in compare mode, count is 0
    expectJump("R1 compare mode", 1, 33);
  endtask

  task automatic testCounter();
    setCount(3);
    check("R3 step", int'(loopCount), 3);
    idle();
    check("R3 hold", int'(loopCount), 3);
    issue(1, 0, 0, 2'b00, 0, 0, 0);
    check("R2 clear", int'(loopCount), 0);
    setCount(255);
    check("R3 top", int'(loopCount), 255);
    issue(0, 1, 0, 2'b00, 0, 0, 0);
    check("R3 wrap", int'(loopCount), 0);
    setCount(5);
    issue(1, 1, 0, 2'b00, 0, 0, 0);
    check("R4 clear wins", int'(loopCount), 0);
  endtask

  task automatic testGreater();
    issue(0, 0, 0, 2'b01, 200, 100, 17);
    expectJump("R6 gt taken", 1, 17);
    idle();
    expectJump("R10 pulse ends", 0, 0);
    issue(0, 0, 0, 2'b01, 100, 200, 18);
    expectJump("R6 gt not", 0, 0);
    issue(0, 0, 0, 2'b01, 8'h80, 8'h7F, 19);
    expectJump("R6 unsigned", 1, 19);
    issue(0, 0, 0, 2'b01, 50, 50, 20);
    expectJump("R6 equal not gt", 0, 0);
  endtask

  task automatic testLess();
    issue(0, 0, 0, 2'b10, 10, 20, 40);
    expectJump("R7 lt taken", 1, 40);
    issue(0, 0, 0, 2'b10, 20, 10, 41);
    expectJump("R7 lt not", 0, 0);
    issue(0, 0, 0, 2'b10, 8'h7F, 8'h80, 42);
    expectJump("R7 unsigned", 1, 42);
  endtask

  task automatic testEqual();
    issue(0, 0, 0, 2'b11, 77, 77, 60);
    expectJump("R8 eq taken", 1, 60);
    issue(0, 0, 0, 2'b11, 77, 78, 61);
    expectJump("R8 eq not", 0, 0);
    issue(0, 0, 0, 2'b00, 77, 77, 62);
    expectJump("R10 no compare", 0, 0);
  endtask

  task automatic testModes();
    setCount(3);
    issue(0, 0, 1, 2'b11, 7, 7, 80);        // flip + eq: old (compare) mode used
    expectJump("R5 old mode", 1, 80);
    issue(0, 0, 0, 2'b11, 99, 3, 81);       // now count mode: count 3 == 3
    expectJump("R9 count source", 1, 81);
    issue(0, 0, 0, 2'b01, 0, 2, 82);        // 3 > 2
    expectJump("R9 count gt", 1, 82);
    issue(0, 1, 0, 2'b11, 99, 3, 83);       // pre-increment value compared
    expectJump("R9 pre-update", 1, 83);
    check("R9 count after", int'(loopCount), 4);
    issue(0, 0, 1, 2'b00, 0, 0, 0);         // back to compare mode
    issue(0, 0, 0, 2'b11, 99, 4, 84);
    expectJump("R5 back to compare", 0, 0);
    issue(0, 0, 0, 2'b11, 4, 4, 85);
    expectJump("R9 top source", 1, 85);
    issue(0, 0, 1, 2'b00, 0, 0, 0);         // count mode, then reset
    @(negedge clk); rst = 1;
    @(posedge clk); #1; rst = 0;
    issue(0, 0, 0, 2'b11, 5, 5, 86);        // compare mode after reset
    expectJump("R1 mode reset", 1, 86);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 0;
    testReset();
    testCounter();
    testGreater();
    testLess();
    testEqual();
    testModes();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule